// File: doc/BRIEF.md
# Utilization-Driven Supply and Clock Level Controller

This block chooses whether a processor core should run from the low or the high global supply rail, with the matching clock setting. It watches two things: the occupancy of the core's input FIFO and the core's stall signal. A core whose FIFO keeps filling, or that hardly ever stalls, cannot keep up with its work, so the block asks for the high level. A core whose FIFO stays nearly empty, or that stalls often, is faster than it needs to be, so the block asks for the low level.

Occupancy samples are smoothed by a low-pass filter before any comparison. The filter is either a moving average over 4, 8 or 16 samples or a first-order recursive filter with a selectable shift. Stall cycles are counted over a programmable window of idle cycles. At the end of each window the count is compared against a pair of thresholds, and the smoothed occupancy is compared against a pair of thresholds. The gap between the two occupancy thresholds gives hysteresis.

A mode input picks where the target level comes from: this hardware decision, a level written by local software, or a fixed level set at build time. The block does not switch the power gates or touch the oscillator. It sends a one-cycle request to a switching sequencer and waits for that sequencer's busy signal to rise and then fall before it takes the new level as current.

Top module: `dvfs_ctrl`

## Requirements
- R1: After reset `level` is 0 (low rail), `req_valid` is 0, `freq_sel` equals `freq_lo` and `occ_filt` is 0.
- R2: With `filt_iir`=0, `occ_filt` is the floor of the mean of the last N strobed samples. N is 4, 8 or 16 for `fir_len` 0, 1 or 2, and 16 for `fir_len` 3. Sample slots that have not been filled since reset count as zero.
- R3: With `filt_iir`=1, an accumulator with FRAC fraction bits is updated on every strobe as acc = acc + (((occ << FRAC) - acc) >>> `iir_shift`), using arithmetic shift. `occ_filt` is acc >> FRAC.
- R4: Both filters change state only in cycles where `occ_stb` is 1. In other cycles `occ_filt` holds its value whatever `occ` does.
- R5: In hardware mode (`mode`=0) a decision is taken after every `win_len` idle cycles. The target becomes 1 if `occ_filt` >= `occ_hi` or the stall count in the window is below `stall_lo`. Raising has priority over lowering. A `stall_lo` of 0 disables the stall-based raise.
- R6: In hardware mode the target becomes 0 if `occ_filt` <= `occ_lo` or the window stall count exceeds `stall_hi`, and no raise condition holds. When neither condition holds the target is kept, so occupancy between the two thresholds causes no request.
- R7: A request (`req_valid` for exactly one cycle) is issued only while no transition is outstanding and `seq_busy` is 0. No request is issued between a request and the fall of `seq_busy` that completes it.
- R8: `req_level` carries the target and always differs from `level`. `req_freq` is `freq_hi` for a level of 1 and `freq_lo` for a level of 0. `level` takes `req_level` in the cycle after `seq_busy`, having risen, falls again. `freq_sel` follows `level` with the same encoding as `req_freq`.
- R9: With `mode`=1 the target is `sw_level`, and occupancy and stalls have no effect on requests.
- R10: With `mode`=2 or 3 the target is the build parameter STATIC_LEVEL, and `sw_level`, occupancy and stalls have no effect on requests.
- R11: The stall window and stall counter restart when a transition completes. In hardware mode the first request after a completion appears `win_len`+2 cycles after `seq_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occ_stb | input | 1 | Occupancy sample strobe |
| occ | input | OCC_W | Input FIFO occupancy sample |
| stall | input | 1 | Core stalled this cycle |
| mode | input | 2 | Target source: 0 hardware, 1 software, 2/3 static |
| filt_iir | input | 1 | 1 selects the recursive filter, 0 the moving average |
| iir_shift | input | 3 | Recursive filter shift k |
| fir_len | input | 2 | Moving average length code |
| occ_hi | input | OCC_W | Raise threshold on filtered occupancy |
| occ_lo | input | OCC_W | Lower threshold on filtered occupancy |
| win_len | input | WIN_W | Stall window length in cycles |
| stall_hi | input | WIN_W | Stall count above which to lower |
| stall_lo | input | WIN_W | Stall count below which to raise |
| sw_level | input | 1 | Level requested by software |
| freq_lo | input | FREQ_W | Frequency code for the low level |
| freq_hi | input | FREQ_W | Frequency code for the high level |
| seq_busy | input | 1 | Switching sequencer busy |
| req_valid | output | 1 | One-cycle transition request |
| req_level | output | 1 | Requested rail level |
| req_freq | output | FREQ_W | Frequency code for the requested level |
| level | output | 1 | Current committed rail level |
| freq_sel | output | FREQ_W | Frequency code for the current level |
| occ_filt | output | OCC_W | Filtered occupancy |

## Verification
The bench builds the block with OCC_W=7, which matches a 64-entry FIFO counted in 7 bits, with WIN_W=16, FRAC=8 and FREQ_W=4. It sets STATIC_LEVEL=1 so that static mode causes a real transition away from the reset level rather than matching it. A window length of 8 and a sequencer that stays busy for three cycles keep each hardware decision and each completed transition within a few dozen cycles. With that short window the timing of the window restart after a completion can be measured to the cycle, and the long 16-sample average and the recursive filter can be checked sample by sample against a model.

// File: rtl/dvfs_ctrl.sv
module dvfs_ctrl #(
  parameter int unsigned OCC_W        = 7,
  parameter int unsigned WIN_W        = 16,
  parameter int unsigned FREQ_W       = 4,
  parameter int unsigned FRAC         = 8,
  parameter bit          STATIC_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              occ_stb,
  input  logic [OCC_W-1:0]  occ,
  input  logic              stall,
  input  logic [1:0]        mode,
  input  logic              filt_iir,
  input  logic [2:0]        iir_shift,
  input  logic [1:0]        fir_len,
  input  logic [OCC_W-1:0]  occ_hi,
  input  logic [OCC_W-1:0]  occ_lo,
  input  logic [WIN_W-1:0]  win_len,
  input  logic [WIN_W-1:0]  stall_hi,
  input  logic [WIN_W-1:0]  stall_lo,
  input  logic              sw_level,
  input  logic [FREQ_W-1:0] freq_lo,
  input  logic [FREQ_W-1:0] freq_hi,
  input  logic              seq_busy,
  output logic              req_valid,
  output logic              req_level,
  output logic [FREQ_W-1:0] req_freq,
  output logic              level,
  output logic [FREQ_W-1:0] freq_sel,
  output logic [OCC_W-1:0]  occ_filt
);
  localparam int unsigned TAPS  = 16;
  localparam int unsigned SUM_W = OCC_W + $clog2(TAPS);
  localparam int unsigned ACC_W = OCC_W + FRAC;
  localparam logic [1:0] S_IDLE = 2'd0, S_WAIT = 2'd1, S_BUSY = 2'd2;

  // moving average
  logic [OCC_W-1:0] hist [TAPS];
  logic [SUM_W-1:0] fir_sum;
  logic [2:0]       n_log;
  logic [4:0]       fir_n;

  assign n_log = (fir_len == 2'd3) ? 3'd4 : 3'(fir_len) + 3'd2;
  assign fir_n = 5'd1 << n_log;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) hist[i] <= '0;
    end else if (occ_stb) begin
      hist[0] <= occ;
      for (int i = 1; i < TAPS; i++) hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    fir_sum = '0;
    for (int i = 0; i < TAPS; i++)
      if (5'(i) < fir_n) fir_sum = fir_sum + SUM_W'(hist[i]);
  end

  // recursive filter
  logic [ACC_W-1:0]        iir_acc;
  logic signed [ACC_W:0]   iir_diff, iir_step;

  assign iir_diff = $signed({1'b0, occ, {FRAC{1'b0}}}) - $signed({1'b0, iir_acc});
  assign iir_step = iir_diff >>> iir_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       iir_acc <= '0;
    else if (occ_stb) iir_acc <= iir_acc + ACC_W'(iir_step);
  end

  assign occ_filt = filt_iir ? iir_acc[ACC_W-1:FRAC] : OCC_W'(fir_sum >> n_log);

  // stall window and hardware decision
  logic [1:0]       st;
  logic [WIN_W-1:0] win_cnt, stall_cnt;
  logic [WIN_W:0]   stall_tot;
  logic             win_end, go_up, go_dn, hw_tgt, target;

  assign stall_tot = {1'b0, stall_cnt} + (WIN_W+1)'(stall);
  assign win_end   = (st == S_IDLE) &&
                     (({1'b0, win_cnt} + (WIN_W+1)'(1)) >= {1'b0, win_len});
  assign go_up     = (occ_filt >= occ_hi) || (stall_tot < {1'b0, stall_lo});
  assign go_dn     = (occ_filt <= occ_lo) || (stall_tot > {1'b0, stall_hi});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt   <= '0;
      stall_cnt <= '0;
      hw_tgt    <= 1'b0;
    end else begin
      if (st != S_IDLE || win_end) begin
        win_cnt   <= '0;
        stall_cnt <= '0;
      end else begin
        win_cnt   <= win_cnt + 1'b1;
        stall_cnt <= WIN_W'(stall_tot);
      end
      if (win_end) begin
        if (go_up)      hw_tgt <= 1'b1;
        else if (go_dn) hw_tgt <= 1'b0;
      end
    end
  end

  assign target = (mode == 2'd0) ? hw_tgt :
                  (mode == 2'd1) ? sw_level : STATIC_LEVEL;

  // request handshake with the switching sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      req_valid <= 1'b0;
      req_level <= 1'b0;
      level     <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      case (st)
        S_IDLE: if (target != level && !seq_busy) begin
          req_valid <= 1'b1;
          req_level <= target;
          st        <= S_WAIT;
        end
        S_WAIT: if (seq_busy) st <= S_BUSY;
        default: if (!seq_busy) begin
          level <= req_level;
          st    <= S_IDLE;
        end
      endcase
    end
  end

  assign req_freq = req_level ? freq_hi : freq_lo;
  assign freq_sel = level ? freq_hi : freq_lo;
endmodule

// File: rtl/dvfs_ctrl_chk.sv
module dvfs_ctrl_chk #(
  parameter bit STATIC_LEVEL = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       sw_level,
  input logic       seq_busy,
  input logic       req_valid,
  input logic       req_level,
  input logic       level
);
  p_req_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !$past(seq_busy));

  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  p_req_differs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_level != level);

  p_level_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> level == req_level);

  p_sw_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(mode) == 2'd1) |-> req_level == $past(sw_level));

  p_static_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(mode[1])) |-> req_level == STATIC_LEVEL);
endmodule

bind dvfs_ctrl dvfs_ctrl_chk #(.STATIC_LEVEL(STATIC_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sw_level(sw_level),
  .seq_busy(seq_busy), .req_valid(req_valid), .req_level(req_level),
  .level(level)
);

// File: tb/dvfs_ctrl_test.sv
module dvfs_ctrl_test;
  localparam int OCC_W = 7, WIN_W = 16, FREQ_W = 4, FRAC = 8;
  localparam logic [FREQ_W-1:0] FLO = 4'd3, FHI = 4'd12;

  logic clk = 0, rst_n = 0;
  logic occ_stb = 0, stall = 0, filt_iir = 0, sw_level = 0, seq_busy = 0;
  logic [OCC_W-1:0] occ = 0, occ_hi = 7'd40, occ_lo = 7'd10;
  logic [1:0] mode = 2'd1, fir_len = 2'd0;
  logic [2:0] iir_shift = 3'd2;
  logic [WIN_W-1:0] win_len = 16'd8, stall_hi = 16'hFFFF, stall_lo = 16'd0;
  logic req_valid, req_level, level;
  logic [FREQ_W-1:0] req_freq, freq_sel;
  logic [OCC_W-1:0] occ_filt;

  always #2.5 clk = ~clk;

  dvfs_ctrl #(.OCC_W(OCC_W), .WIN_W(WIN_W), .FREQ_W(FREQ_W), .FRAC(FRAC),
              .STATIC_LEVEL(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .occ_stb(occ_stb), .occ(occ), .stall(stall),
    .mode(mode), .filt_iir(filt_iir), .iir_shift(iir_shift), .fir_len(fir_len),
    .occ_hi(occ_hi), .occ_lo(occ_lo), .win_len(win_len), .stall_hi(stall_hi),
    .stall_lo(stall_lo), .sw_level(sw_level), .freq_lo(FLO), .freq_hi(FHI),
    .seq_busy(seq_busy), .req_valid(req_valid), .req_level(req_level),
    .req_freq(req_freq), .level(level), .freq_sel(freq_sel), .occ_filt(occ_filt));

  int checks = 0, errors = 0;
  int expq[$];
  int reqs = 0, cyc = 0, last_fall = 0, last_lat = 0, bcnt = 0;
  int hist[16];
  int iy = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected requests; also models the switching sequencer
  always @(negedge clk) begin
    cyc++;
    if (rst_n && req_valid) begin
      reqs++;
      last_lat = cyc - last_fall;
      if (seq_busy) chk("R7 request while busy", 1, 0);
      if (expq.size() == 0) chk("R8 unexpected request level", int'(req_level), -1);
      else chk("R8 request level", int'(req_level), expq.pop_front());
      chk("R8 req_freq", int'(req_freq), req_level ? int'(FHI) : int'(FLO));
    end
    if (bcnt > 0) begin
      bcnt--;
      if (bcnt == 0) begin seq_busy = 0; last_fall = cyc; end
    end else if (rst_n && req_valid) begin
      seq_busy = 1; bcnt = 3;
    end
  end

  function automatic int exp_filt();
    int s = 0, n;
    if (filt_iir) return iy >>> FRAC;
    n = (fir_len == 2'd3) ? 16 : (4 << fir_len);
    for (int i = 0; i < n; i++) s += hist[i];
    return s / n;
  endfunction

  task automatic smp(input int v, input string tag);
    int d;
    occ = 7'(v); occ_stb = 1;
    @(negedge clk);
    occ_stb = 0;
    for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = v;
    d = v * (1 << FRAC) - iy;
    iy = iy + (d >>> iir_shift);
    chk(tag, int'(occ_filt), exp_filt());
  endtask

  task automatic wait_level(input int v, input string tag);
    for (int i = 0; i < 300; i++) begin
      if (int'(level) == v) break;
      @(negedge clk);
    end
    chk(tag, int'(level), v);
    chk({tag, " freq_sel"}, int'(freq_sel), v ? int'(FHI) : int'(FLO));
  endtask

  task automatic quiet(input int n, input string tag, input int lv);
    int r0 = reqs;
    repeat (n) @(negedge clk);
    chk({tag, " no request"}, reqs - r0, 0);
    chk({tag, " level kept"}, int'(level), lv);
  endtask

  initial begin
    int held, r0;
    for (int i = 0; i < 16; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 level", int'(level), 0);
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 freq_sel", int'(freq_sel), int'(FLO));
    chk("R1 occ_filt", int'(occ_filt), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 moving average, lengths 4, 8, 16
    smp(8, "R2 fir4"); smp(20, "R2 fir4"); smp(33, "R2 fir4"); smp(47, "R2 fir4");
    smp(63, "R2 fir4");
    fir_len = 2'd1; #1 chk("R2 fir8 switch", int'(occ_filt), exp_filt());
    smp(5, "R2 fir8"); smp(17, "R2 fir8");
    fir_len = 2'd2; smp(99, "R2 fir16"); smp(120, "R2 fir16");
    fir_len = 2'd3; smp(1, "R2 fir16 code3");
    // R3 recursive filter
    filt_iir = 1; #1 chk("R3 iir select", int'(occ_filt), exp_filt());
    smp(64, "R3 iir k2"); smp(64, "R3 iir k2");
    iir_shift = 3'd0; smp(30, "R3 iir k0");
    iir_shift = 3'd3; smp(100, "R3 iir k3"); smp(0, "R3 iir k3 falling");
    // R4 no strobe, no change
    held = occ_filt;
    occ = 7'd127;
    repeat (3) @(negedge clk);
    chk("R4 iir hold", int'(occ_filt), held);
    filt_iir = 0; fir_len = 2'd0; #1 held = occ_filt;
    repeat (3) @(negedge clk);
    chk("R4 fir hold", int'(occ_filt), held);

    // hardware mode, continuous sampling
    filt_iir = 0; fir_len = 2'd0; occ_stb = 1; mode = 2'd0;
    occ = 7'd60; expq.push_back(1);
    wait_level(1, "R5 raise on occupancy");
    occ = 7'd25;
    quiet(40, "R6 hysteresis", 1);
    occ = 7'd2; expq.push_back(0);
    wait_level(0, "R6 lower on occupancy");
    occ = 7'd25; stall = 0; stall_lo = 16'd3; expq.push_back(1);
    wait_level(1, "R5 raise on rare stalls");
    stall_lo = 16'd0; stall = 1; stall_hi = 16'd4; expq.push_back(0);
    r0 = reqs;
    wait (reqs == r0 + 1);
    #1 chk("R11 window restarts after completion", last_lat, 10);
    wait_level(0, "R6 lower on frequent stalls");
    stall = 0; stall_hi = 16'hFFFF;
    quiet(30, "R6 hold in band", 0);

    // software mode: target held high through the busy period
    @(negedge clk);
    mode = 2'd1; sw_level = 1; occ = 7'd2; expq.push_back(1);
    wait_level(1, "R9 software raise");
    quiet(40, "R9 occupancy ignored", 1);
    sw_level = 0; expq.push_back(0);
    wait_level(0, "R9 software lower");
    chk("R7 pending requests drained", expq.size(), 0);

    // static mode
    mode = 2'd2; occ = 7'd2; stall = 1; stall_hi = 16'd0; expq.push_back(1);
    wait_level(1, "R10 static level");
    sw_level = 0; occ = 7'd0;
    quiet(30, "R10 software and occupancy ignored", 1);
    mode = 2'd3;
    quiet(20, "R10 mode 3 static", 1);

    chk("R8 all expected requests seen", expq.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule